// File: doc/BRIEF.md
# Bus Backoff Requester

This controller lets a secondary bus master take the shared bus away from a primary master and later give it back. It watches the primary's address strobe together with the memory's ready and burst-ready returns, which tells it whether a primary cycle is in flight. When the secondary master raises its request, the controller drives a backoff signal to the primary. In two-clock mode it first drives an address-hold signal for one clock. That step keeps the primary from issuing a strobe in the same clock that backoff lands, so the primary's strobe is never left floating active.

Once backoff is asserted, the controller decides when the secondary master may begin. If a primary cycle was in progress, it waits for memory to return ready or burst-ready. That return is the handshake showing memory can accept a new cycle; memory may treat backoff as a last-transfer marker. If the bus was idle, the grant follows a fixed delay after backoff. Backoff stays asserted while the secondary master owns the bus. The secondary master's release drops backoff, and the primary then restarts its aborted cycle on its own.

The controller is a six-state machine with these states:
- `ST_IDLE`: waiting for a request.
- `ST_HOLD`: address-hold only.
- `ST_BO_WAIT`: backoff asserted, waiting for memory to return ready.
- `ST_BO_DELAY`: backoff asserted, counting the fixed idle delay.
- `ST_OWNED`: backoff and grant asserted.
- `ST_RELEASE`: one dead clock after release.

Its transitions are:
- IDLE→HOLD: on a request in two-clock mode.
- IDLE→BO_WAIT / IDLE→BO_DELAY: on a request in single-clock mode.
- HOLD→BO_WAIT / HOLD→BO_DELAY: always, after one clock.
- BO_WAIT→OWNED: on ready.
- BO_DELAY→OWNED: when the delay expires.
- OWNED→RELEASE: on release.
- RELEASE→IDLE: always.

Whenever the machine picks between the two backoff states, it picks BO_WAIT if a cycle is in progress and BO_DELAY otherwise.

Top module: `bkoff_requester`

## Requirements
- R1: While reset is asserted, and after it, addr_hold, backoff and alt_grant are all low.
- R2: In two-clock mode (two_clk_mode=1), a request sampled in idle raises addr_hold for exactly one clock. In the following clock backoff is high and addr_hold is low, and the two are never high together.
- R3: In single-clock mode (two_clk_mode=0), a request sampled in idle raises backoff one clock later, and addr_hold stays low.
- R4: If no primary cycle is in progress, alt_grant rises exactly IDLE_GRANT_DLY (default 2) clocks after backoff rises.
- R5: If a primary cycle is in progress when backoff is raised, alt_grant stays low until mem_ready or mem_burst_ready is sampled high. It then rises one clock after that sample.
- R6: pri_strobe marks a primary cycle in progress. mem_ready ends it. mem_burst_ready ends it only when mem_last is high in the same clock; without mem_last the cycle stays in progress.
- R7: backoff and alt_grant stay high until alt_release is sampled while granted. Both are low one clock after that sample, and alt_grant is never high without backoff.
- R8: A request sampled in the clock right after a release is ignored, and alt_release has no effect while not granted.
- R9: A pri_strobe sampled in the same clock as the backoff decision counts as a cycle in progress, so the grant waits for ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| two_clk_mode | input | 1 | 1 = raise address-hold one clock before backoff |
| alt_req | input | 1 | Secondary master asks for the bus |
| alt_release | input | 1 | Secondary master gives the bus back |
| pri_strobe | input | 1 | Primary address strobe (active high) |
| mem_ready | input | 1 | Memory ready, ends a cycle |
| mem_burst_ready | input | 1 | Memory burst-ready |
| mem_last | input | 1 | Last transfer of a burst |
| addr_hold | output | 1 | Address-hold to the primary, registered |
| backoff | output | 1 | Backoff to the primary, registered |
| alt_grant | output | 1 | Secondary master may start cycles, registered |

## Verification
The primary's address strobe can arrive in the same clock as the backoff decision. The bench provokes this in single-clock mode by raising alt_req and pri_strobe together from an idle bus. It then checks that the grant does not appear two clocks after backoff, as it would on an idle bus, and only follows a later mem_ready. A second overlap comes from burst-ready without last-transfer just before a request. The bench judges this case by the grant still waiting for a ready.

// File: rtl/bkoff_pkg.sv
package bkoff_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_HOLD     = 3'd1,
        ST_BO_WAIT  = 3'd2,
        ST_BO_DELAY = 3'd3,
        ST_OWNED    = 3'd4,
        ST_RELEASE  = 3'd5
    } bo_state_e;

endpackage

// File: rtl/bkoff_busy_track.sv
// Tracks whether a primary bus cycle is in flight.
module bkoff_busy_track (
    input  logic clk,
    input  logic rst_n,
    input  logic pri_strobe,
    input  logic mem_ready,
    input  logic mem_burst_ready,
    input  logic mem_last,
    output logic busy
);

    logic cycle_end;

    assign cycle_end = mem_ready | (mem_burst_ready & mem_last);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (pri_strobe) begin
            busy <= 1'b1;
        end else if (cycle_end) begin
            busy <= 1'b0;
        end
    end

endmodule

// File: rtl/bkoff_grant_timer.sv
// Counts clocks spent in the idle-bus delay state.
module bkoff_grant_timer #(
    parameter int IDLE_GRANT_DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int CW = (IDLE_GRANT_DLY < 2) ? 1 : $clog2(IDLE_GRANT_DLY + 1);
    localparam logic [CW-1:0] LAST = CW'(IDLE_GRANT_DLY - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == LAST);

endmodule

// File: rtl/bkoff_fsm.sv
// Sequencing state machine with registered outputs.
module bkoff_fsm
    import bkoff_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic two_clk_mode,
    input  logic alt_req,
    input  logic alt_release,
    input  logic started,
    input  logic bus_done,
    input  logic delay_done,
    output logic delay_run,
    output logic addr_hold,
    output logic backoff,
    output logic alt_grant
);

    bo_state_e state_q, state_d;
    bo_state_e bo_pick;

    // Pick the backoff state from the bus activity.
    always_comb begin
        bo_pick = started ? ST_BO_WAIT : ST_BO_DELAY;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (alt_req) begin
                    state_d = two_clk_mode ? ST_HOLD : bo_pick;
                end
            end
            ST_HOLD:     state_d = bo_pick;
            ST_BO_WAIT:  if (bus_done)    state_d = ST_OWNED;
            ST_BO_DELAY: if (delay_done)  state_d = ST_OWNED;
            ST_OWNED:    if (alt_release) state_d = ST_RELEASE;
            ST_RELEASE:  state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register, decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_hold <= 1'b0;
            backoff   <= 1'b0;
            alt_grant <= 1'b0;
        end else begin
            addr_hold <= (state_d == ST_HOLD);
            backoff   <= (state_d == ST_BO_WAIT) || (state_d == ST_BO_DELAY)
                         || (state_d == ST_OWNED);
            alt_grant <= (state_d == ST_OWNED);
        end
    end

    assign delay_run = (state_q == ST_BO_DELAY);

endmodule

// File: rtl/bkoff_requester.sv
module bkoff_requester #(
    parameter int IDLE_GRANT_DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic two_clk_mode,
    input  logic alt_req,
    input  logic alt_release,
    input  logic pri_strobe,
    input  logic mem_ready,
    input  logic mem_burst_ready,
    input  logic mem_last,
    output logic addr_hold,
    output logic backoff,
    output logic alt_grant
);

    logic busy;
    logic started;
    logic bus_done;
    logic delay_run;
    logic delay_done;

    bkoff_busy_track u_busy (
        .clk             (clk),
        .rst_n           (rst_n),
        .pri_strobe      (pri_strobe),
        .mem_ready       (mem_ready),
        .mem_burst_ready (mem_burst_ready),
        .mem_last        (mem_last),
        .busy            (busy)
    );

    // A strobe in the deciding clock counts as a started cycle.
    assign started  = busy | pri_strobe;
    // Backoff acts as last transfer, so any ready ends the wait.
    assign bus_done = mem_ready | mem_burst_ready;

    bkoff_grant_timer #(
        .IDLE_GRANT_DLY (IDLE_GRANT_DLY)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (delay_run),
        .done  (delay_done)
    );

    bkoff_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .two_clk_mode (two_clk_mode),
        .alt_req      (alt_req),
        .alt_release  (alt_release),
        .started      (started),
        .bus_done     (bus_done),
        .delay_done   (delay_done),
        .delay_run    (delay_run),
        .addr_hold    (addr_hold),
        .backoff      (backoff),
        .alt_grant    (alt_grant)
    );

endmodule

// File: rtl/bkoff_checker.sv
module bkoff_checker (
    input logic clk,
    input logic rst_n,
    input logic two_clk_mode,
    input logic alt_req,
    input logic alt_release,
    input logic pri_strobe,
    input logic mem_ready,
    input logic mem_burst_ready,
    input logic mem_last,
    input logic addr_hold,
    input logic backoff,
    input logic alt_grant
);

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (!addr_hold && !backoff && !alt_grant || $time == 0)
                else $error("outputs active in reset");
        end
    end

    assert_hold_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hold |=> !addr_hold);

    assert_hold_then_backoff_R2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hold |=> backoff);

    assert_hold_backoff_apart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_hold && backoff));

    assert_hold_needs_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_hold) |-> $past(two_clk_mode));

    assert_grant_under_backoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
        alt_grant |-> backoff);

    assert_release_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_grant && alt_release) |=> (!backoff && !alt_grant));

    assert_grant_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_grant && !alt_release) |=> alt_grant);

endmodule

bind bkoff_requester bkoff_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .two_clk_mode    (two_clk_mode),
    .alt_req         (alt_req),
    .alt_release     (alt_release),
    .pri_strobe      (pri_strobe),
    .mem_ready       (mem_ready),
    .mem_burst_ready (mem_burst_ready),
    .mem_last        (mem_last),
    .addr_hold       (addr_hold),
    .backoff         (backoff),
    .alt_grant       (alt_grant)
);

// File: tb/bkoff_requester_test.sv
module bkoff_requester_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic two_clk_mode = 1'b0;
    logic alt_req = 1'b0;
    logic alt_release = 1'b0;
    logic pri_strobe = 1'b0;
    logic mem_ready = 1'b0;
    logic mem_burst_ready = 1'b0;
    logic mem_last = 1'b0;
    logic addr_hold, backoff, alt_grant;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    bkoff_requester uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .two_clk_mode    (two_clk_mode),
        .alt_req         (alt_req),
        .alt_release     (alt_release),
        .pri_strobe      (pri_strobe),
        .mem_ready       (mem_ready),
        .mem_burst_ready (mem_burst_ready),
        .mem_last        (mem_last),
        .addr_hold       (addr_hold),
        .backoff         (backoff),
        .alt_grant       (alt_grant)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic do_release(input string req);
        alt_release = 1'b1;
        step();
        alt_release = 1'b0;
        check(req, "backoff after release", backoff, 1'b0);
        check(req, "grant after release", alt_grant, 1'b0);
        step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        alt_req = 1'b1;
        step(); step();
        check("R1", "hold in reset", addr_hold, 1'b0);
        check("R1", "backoff in reset", backoff, 1'b0);
        check("R1", "grant in reset", alt_grant, 1'b0);
        alt_req = 1'b0;
        rst_n = 1'b1;
        step();
        check("R1", "backoff after reset", backoff, 1'b0);
    endtask

    task automatic t_two_clk_idle();
        two_clk_mode = 1'b1;
        alt_req = 1'b1;
        step();
        alt_req = 1'b0;
        check("R2", "hold first clock", addr_hold, 1'b1);
        check("R2", "no backoff first clock", backoff, 1'b0);
        step();
        check("R2", "hold dropped", addr_hold, 1'b0);
        check("R2", "backoff second clock", backoff, 1'b1);
        check("R4", "no grant yet", alt_grant, 1'b0);
        step();
        check("R4", "no grant one clock on", alt_grant, 1'b0);
        step();
        check("R4", "grant two clocks after backoff", alt_grant, 1'b1);
        step(); step();
        check("R7", "backoff held", backoff, 1'b1);
        check("R7", "grant held", alt_grant, 1'b1);
        do_release("R7");
    endtask

    task automatic t_single_idle();
        two_clk_mode = 1'b0;
        alt_req = 1'b1;
        step();
        alt_req = 1'b0;
        check("R3", "backoff one clock on", backoff, 1'b1);
        check("R3", "no hold", addr_hold, 1'b0);
        step();
        check("R4", "no grant single", alt_grant, 1'b0);
        step();
        check("R4", "grant single", alt_grant, 1'b1);
        do_release("R7");
    endtask

    task automatic t_mid_cycle();
        two_clk_mode = 1'b1;
        pri_strobe = 1'b1;
        step();
        pri_strobe = 1'b0;
        alt_req = 1'b1;
        step();
        alt_req = 1'b0;
        check("R2", "hold mid cycle", addr_hold, 1'b1);
        step();
        check("R5", "backoff mid cycle", backoff, 1'b1);
        step(); step(); step();
        check("R5", "grant waits for ready", alt_grant, 1'b0);
        mem_ready = 1'b1;
        step();
        mem_ready = 1'b0;
        check("R5", "grant after ready", alt_grant, 1'b1);
        do_release("R7");
    endtask

    task automatic t_burst_nolast();
        two_clk_mode = 1'b0;
        pri_strobe = 1'b1;
        step();
        pri_strobe = 1'b0;
        mem_burst_ready = 1'b1;
        mem_last = 1'b0;
        step();
        mem_burst_ready = 1'b0;
        alt_req = 1'b1;
        step();
        alt_req = 1'b0;
        check("R6", "backoff", backoff, 1'b1);
        step(); step(); step();
        check("R6", "still busy, no grant", alt_grant, 1'b0);
        mem_burst_ready = 1'b1;
        step();
        mem_burst_ready = 1'b0;
        check("R5", "grant after burst ready", alt_grant, 1'b1);
        mem_ready = 1'b1;
        step();
        mem_ready = 1'b0;
        do_release("R7");
    endtask

    task automatic t_burst_last();
        two_clk_mode = 1'b0;
        pri_strobe = 1'b1;
        step();
        pri_strobe = 1'b0;
        mem_burst_ready = 1'b1;
        mem_last = 1'b1;
        step();
        mem_burst_ready = 1'b0;
        mem_last = 1'b0;
        alt_req = 1'b1;
        step();
        alt_req = 1'b0;
        step();
        check("R6", "idle path no grant", alt_grant, 1'b0);
        step();
        check("R6", "idle path grant after last", alt_grant, 1'b1);
        do_release("R7");
    endtask

    task automatic t_coincide();
        two_clk_mode = 1'b0;
        alt_req = 1'b1;
        pri_strobe = 1'b1;
        step();
        alt_req = 1'b0;
        pri_strobe = 1'b0;
        check("R9", "backoff", backoff, 1'b1);
        step(); step(); step();
        check("R9", "no idle-delay grant", alt_grant, 1'b0);
        mem_ready = 1'b1;
        step();
        mem_ready = 1'b0;
        check("R9", "grant after ready", alt_grant, 1'b1);
        do_release("R7");
    endtask

    task automatic t_ignore();
        two_clk_mode = 1'b0;
        alt_release = 1'b1;
        step();
        alt_release = 1'b0;
        step();
        check("R8", "idle release no backoff", backoff, 1'b0);
        alt_req = 1'b1;
        step();
        alt_req = 1'b0;
        step(); step();
        check("R8", "grant after idle release", alt_grant, 1'b1);
        alt_release = 1'b1;
        step();
        alt_release = 1'b0;
        alt_req = 1'b1;
        step();
        alt_req = 1'b0;
        step();
        check("R8", "request in release ignored, backoff", backoff, 1'b0);
        check("R8", "request in release ignored, hold", addr_hold, 1'b0);
        step();
        check("R8", "still quiet", backoff, 1'b0);
    endtask

    initial begin
        #1;
        t_reset();
        t_two_clk_idle();
        t_single_idle();
        t_mid_cycle();
        t_burst_nolast();
        t_burst_last();
        t_coincide();
        t_ignore();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule